// File: doc/BRIEF.md
# Thermal Sensor Polling Sequencer

This block runs a shared auxiliary converter on behalf of a thermal monitor that has no converter of its own. On a programmable period it walks through the enabled sensing points and, for each one, acts as a bus master. It optionally sets the converter's channel mux and the per-point sensor selector through programmed write addresses. It starts a conversion by writing an enable word. It then reads a programmed status address until a programmable valid bit shows, and stores the extracted voltage in that point's result register.

The period is a programmable unit, a count of 256-clock blocks, multiplied by a programmable number of units per round. The valid bit has a programmable position and polarity. The voltage can come from the same word as the valid bit or from a second read, and is right-shifted by a programmable amount before its low 12 bits are kept. If a point stays invalid for too many polls, the block raises a one-cycle interrupt and moves on. Configuration arrives on static input ports driven by a register block elsewhere. Results are fetched through a small read port, and each read clears that point's update flag.

Top module: `tpm_poller`

## Requirements
- R1: After synchronous reset `m_req` and `irq_timeout` are low, `upd_flags` is all zero and every result register reads 0.
- R2: A round starts once every `cfg_unit`×256×`cfg_round` clocks counted from reset; if `cfg_unit` or `cfg_round` is zero, no round starts and no bus request is made.
- R3: In a round the points whose `cfg_en_mask` bit is 1 are served in ascending index order. Each point gets, in order: a write of `cfg_mux_val` to `cfg_mux_addr` when `cfg_wr_ctl[1]`=1, a write of `cfg_sel_val[p]` to `cfg_sel_addr` when `cfg_wr_ctl[0]`=1, a write of `cfg_en_val` to `cfg_en_addr`, then a read of `cfg_vld_addr`. The bus writes only these addresses.
- R4: A read word is valid when bit `cfg_vld_pos` equals `cfg_vld_high` (1 = active high, 0 = active low).
- R5: After an invalid poll the status address is read again. Acknowledges of successive polls of one point are at least `cfg_gap`+4 clocks apart when the bus acknowledges two clocks after a request.
- R6: When the number of invalid polls of a point reaches `cfg_limit` (0 and 1 both allow one poll), `irq_timeout` pulses high for exactly one clock. That point's result and update flag are left unchanged, and the round moves on.
- R7: With `cfg_split`=1, a valid poll is followed by a read of `cfg_volt_addr`, and the voltage comes from that word. With `cfg_split`=0 it comes from the status word itself. Bus reads touch only these two addresses.
- R8: The stored result is bits 11:0 of the voltage word shifted right by `cfg_shift`.
- R9: Storing a result sets that point's bit of `upd_flags`. A read (`rd_en` with `rd_idx`) returns the result on `rd_data` one clock later and clears that flag.
- R10: Once `m_req` is raised, `m_addr`, `m_we` and `m_wdata` hold steady until `m_ack`, and only one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unit | input | 10 | Time unit in 256-clock blocks |
| cfg_round | input | 10 | Units between rounds |
| cfg_en_mask | input | NPTS | Point enable mask |
| cfg_wr_ctl | input | 2 | Bit1 enables mux write, bit0 selector write |
| cfg_mux_addr | input | AW | Channel mux write address |
| cfg_mux_val | input | DW | Channel mux write value |
| cfg_sel_addr | input | AW | Sensor selector write address |
| cfg_sel_val | input | NPTS×DW | Per-point selector values |
| cfg_en_addr | input | AW | Conversion enable address |
| cfg_en_val | input | DW | Conversion enable value |
| cfg_vld_addr | input | AW | Status (valid) read address |
| cfg_volt_addr | input | AW | Voltage read address |
| cfg_split | input | 1 | 1 = voltage from separate read |
| cfg_vld_pos | input | 5 | Valid bit position |
| cfg_vld_high | input | 1 | Valid polarity, 1 = active high |
| cfg_shift | input | 5 | Voltage right shift |
| cfg_gap | input | 16 | Idle clocks between polls |
| cfg_limit | input | 32 | Invalid-poll limit |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write enable |
| m_addr | output | AW | Bus address |
| m_wdata | output | DW | Bus write data |
| m_ack | input | 1 | Bus acknowledge |
| m_rdata | input | DW | Bus read data, valid with ack |
| irq_timeout | output | 1 | Poll timeout pulse |
| rd_en | input | 1 | Result read strobe |
| rd_idx | input | IW | Result index |
| rd_data | output | 12 | Result read data |
| upd_flags | output | NPTS | Per-point update flags |

## Verification
The sequence is exercised with every combination of the two mux-write gates, with sparse masks (points 0 and 2, a lone point 1, a lone point 3) to show ascending order and skipping, and with both valid polarities at different bit positions. A status word that is valid on the first poll is contrasted with one that needs two extra polls, which separates a missing poll gap or a wrong polarity from correct retrying. The combined and split voltage reads are each run with distinct data, one with a nonzero shift. A never-valid point at a limit of two shows the single interrupt pulse and the untouched result, and a zero round count shows that the timer holds off all traffic.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_BUS, S_GAP} seq_state_e;
  typedef enum logic [2:0] {PH_MUX, PH_SEL, PH_ENA, PH_VLD, PH_VOLT} bus_phase_e;
endpackage

// File: rtl/tpm_timebase.sv
module tpm_timebase #(
  parameter int PRE_W = 8,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_unit,
  input  logic [CW-1:0] cfg_round,
  output logic          round_tick
);
  logic [PRE_W-1:0] pre;
  logic [CW-1:0]    ucnt, rcnt;
  logic             utick;

  assign utick = (&pre) && (cfg_unit != '0) && (ucnt >= cfg_unit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre        <= '0;
      ucnt       <= '0;
      rcnt       <= '0;
      round_tick <= 1'b0;
    end else begin
      pre        <= pre + 1'b1;
      round_tick <= 1'b0;
      if (&pre) begin
        if (utick)               ucnt <= '0;
        else if (cfg_unit != '0) ucnt <= ucnt + 1'b1;
      end
      if (utick && cfg_round != '0) begin
        if (rcnt >= cfg_round - 1'b1) begin
          rcnt       <= '0;
          round_tick <= 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tpm_seq.sv
module tpm_seq
  import tpm_pkg::*;
#(
  parameter int NPTS = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RW   = 12,
  parameter int GW   = 16,
  parameter int TW   = 32,
  parameter int IW   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic [NPTS-1:0]          cfg_en_mask,
  input  logic [1:0]               cfg_wr_ctl,
  input  logic [AW-1:0]            cfg_mux_addr,
  input  logic [DW-1:0]            cfg_mux_val,
  input  logic [AW-1:0]            cfg_sel_addr,
  input  logic [NPTS-1:0][DW-1:0]  cfg_sel_val,
  input  logic [AW-1:0]            cfg_en_addr,
  input  logic [DW-1:0]            cfg_en_val,
  input  logic [AW-1:0]            cfg_vld_addr,
  input  logic [AW-1:0]            cfg_volt_addr,
  input  logic                     cfg_split,
  input  logic [4:0]               cfg_vld_pos,
  input  logic                     cfg_vld_high,
  input  logic [4:0]               cfg_shift,
  input  logic [GW-1:0]            cfg_gap,
  input  logic [TW-1:0]            cfg_limit,
  output logic                     m_req,
  output logic                     m_we,
  output logic [AW-1:0]            m_addr,
  output logic [DW-1:0]            m_wdata,
  input  logic                     m_ack,
  input  logic [DW-1:0]            m_rdata,
  output logic                     st_we,
  output logic [IW-1:0]            st_idx,
  output logic [RW-1:0]            st_val,
  output logic                     irq
);
  localparam int IW1 = IW + 1;

  seq_state_e     state;
  bus_phase_e     ph, first_ph, after_mux;
  logic [IW1-1:0] scan;
  logic [IW-1:0]  cur, pidx;
  logic           found, pend, valid;
  logic [TW-1:0]  fails;
  logic [GW-1:0]  gcnt;
  logic [DW-1:0]  shifted;

  // lowest enabled point at or above the scan position
  always_comb begin
    found = 1'b0;
    pidx  = '0;
    for (int i = NPTS - 1; i >= 0; i--) begin
      if (cfg_en_mask[i] && IW1'(i) >= scan) begin
        found = 1'b1;
        pidx  = IW'(i);
      end
    end
  end

  assign first_ph  = cfg_wr_ctl[1] ? PH_MUX : (cfg_wr_ctl[0] ? PH_SEL : PH_ENA);
  assign after_mux = cfg_wr_ctl[0] ? PH_SEL : PH_ENA;
  assign valid     = (m_rdata[cfg_vld_pos] == cfg_vld_high);
  assign shifted   = m_rdata >> cfg_shift;

  // bus fields follow the registered phase; configuration is static
  always_comb begin
    m_we    = 1'b0;
    m_addr  = cfg_vld_addr;
    m_wdata = '0;
    unique case (ph)
      PH_MUX:  begin m_we = 1'b1; m_addr = cfg_mux_addr; m_wdata = cfg_mux_val;      end
      PH_SEL:  begin m_we = 1'b1; m_addr = cfg_sel_addr; m_wdata = cfg_sel_val[cur]; end
      PH_ENA:  begin m_we = 1'b1; m_addr = cfg_en_addr;  m_wdata = cfg_en_val;       end
      PH_VOLT: m_addr = cfg_volt_addr;
      default: m_addr = cfg_vld_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ph    <= PH_VLD;
      scan  <= '0;
      cur   <= '0;
      pend  <= 1'b0;
      fails <= '0;
      gcnt  <= '0;
      m_req <= 1'b0;
      st_we <= 1'b0;
      st_idx <= '0;
      st_val <= '0;
      irq   <= 1'b0;
    end else begin
      st_we <= 1'b0;
      irq   <= 1'b0;
      if (go && state != S_IDLE) pend <= 1'b1;
      unique case (state)
        S_IDLE: if (go || pend) begin
          pend  <= 1'b0;
          scan  <= '0;
          state <= S_PICK;
        end
        S_PICK: if (found) begin
          cur   <= pidx;
          scan  <= IW1'(pidx) + 1'b1;
          fails <= '0;
          ph    <= first_ph;
          m_req <= 1'b1;
          state <= S_BUS;
        end else begin
          state <= S_IDLE;
        end
        S_BUS: if (m_ack) begin
          m_req <= 1'b0;
          unique case (ph)
            PH_MUX: begin ph <= after_mux; m_req <= 1'b1; end
            PH_SEL: begin ph <= PH_ENA;    m_req <= 1'b1; end
            PH_ENA: begin ph <= PH_VLD;    m_req <= 1'b1; end
            PH_VLD: begin
              if (valid) begin
                if (cfg_split) begin
                  ph    <= PH_VOLT;
                  m_req <= 1'b1;
                end else begin
                  st_we  <= 1'b1;
                  st_idx <= cur;
                  st_val <= shifted[RW-1:0];
                  state  <= S_PICK;
                end
              end else if (fails + 1'b1 >= cfg_limit) begin
                irq   <= 1'b1;
                state <= S_PICK;
              end else begin
                fails <= fails + 1'b1;
                gcnt  <= '0;
                state <= S_GAP;
              end
            end
            default: begin
              st_we  <= 1'b1;
              st_idx <= cur;
              st_val <= shifted[RW-1:0];
              state  <= S_PICK;
            end
          endcase
        end
        default: begin
          if (gcnt >= cfg_gap) begin
            ph    <= PH_VLD;
            m_req <= 1'b1;
            state <= S_BUS;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tpm_results.sv
module tpm_results #(
  parameter int NPTS = 4,
  parameter int RW   = 12,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_we,
  input  logic [IW-1:0]   st_idx,
  input  logic [RW-1:0]   st_val,
  input  logic            rd_en,
  input  logic [IW-1:0]   rd_idx,
  output logic [RW-1:0]   rd_data,
  output logic [NPTS-1:0] upd_flags
);
  logic [RW-1:0] res [NPTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPTS; i++) res[i] <= '0;
      rd_data   <= '0;
      upd_flags <= '0;
    end else begin
      if (rd_en) begin
        rd_data           <= res[rd_idx];
        upd_flags[rd_idx] <= 1'b0;
      end
      if (st_we) begin
        res[st_idx]       <= st_val;
        upd_flags[st_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpm_poller.sv
module tpm_poller #(
  parameter int NPTS  = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PRE_W = 8,
  parameter int CW    = 10,
  parameter int GW    = 16,
  parameter int TW    = 32,
  localparam int RW   = 12,
  localparam int IW   = (NPTS > 1) ? $clog2(NPTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            cfg_unit,
  input  logic [CW-1:0]            cfg_round,
  input  logic [NPTS-1:0]          cfg_en_mask,
  input  logic [1:0]               cfg_wr_ctl,
  input  logic [AW-1:0]            cfg_mux_addr,
  input  logic [DW-1:0]            cfg_mux_val,
  input  logic [AW-1:0]            cfg_sel_addr,
  input  logic [NPTS-1:0][DW-1:0]  cfg_sel_val,
  input  logic [AW-1:0]            cfg_en_addr,
  input  logic [DW-1:0]            cfg_en_val,
  input  logic [AW-1:0]            cfg_vld_addr,
  input  logic [AW-1:0]            cfg_volt_addr,
  input  logic                     cfg_split,
  input  logic [4:0]               cfg_vld_pos,
  input  logic                     cfg_vld_high,
  input  logic [4:0]               cfg_shift,
  input  logic [GW-1:0]            cfg_gap,
  input  logic [TW-1:0]            cfg_limit,
  output logic                     m_req,
  output logic                     m_we,
  output logic [AW-1:0]            m_addr,
  output logic [DW-1:0]            m_wdata,
  input  logic                     m_ack,
  input  logic [DW-1:0]            m_rdata,
  output logic                     irq_timeout,
  input  logic                     rd_en,
  input  logic [IW-1:0]            rd_idx,
  output logic [RW-1:0]            rd_data,
  output logic [NPTS-1:0]          upd_flags
);
  logic          round_tick, st_we;
  logic [IW-1:0] st_idx;
  logic [RW-1:0] st_val;

  tpm_timebase #(.PRE_W(PRE_W), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .cfg_unit(cfg_unit), .cfg_round(cfg_round),
    .round_tick(round_tick));

  tpm_seq #(.NPTS(NPTS), .AW(AW), .DW(DW), .RW(RW), .GW(GW), .TW(TW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .go(round_tick),
    .cfg_en_mask(cfg_en_mask), .cfg_wr_ctl(cfg_wr_ctl),
    .cfg_mux_addr(cfg_mux_addr), .cfg_mux_val(cfg_mux_val),
    .cfg_sel_addr(cfg_sel_addr), .cfg_sel_val(cfg_sel_val),
    .cfg_en_addr(cfg_en_addr), .cfg_en_val(cfg_en_val),
    .cfg_vld_addr(cfg_vld_addr), .cfg_volt_addr(cfg_volt_addr),
    .cfg_split(cfg_split), .cfg_vld_pos(cfg_vld_pos), .cfg_vld_high(cfg_vld_high),
    .cfg_shift(cfg_shift), .cfg_gap(cfg_gap), .cfg_limit(cfg_limit),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .st_we(st_we), .st_idx(st_idx), .st_val(st_val), .irq(irq_timeout));

  tpm_results #(.NPTS(NPTS), .RW(RW), .IW(IW)) u_res (
    .clk(clk), .rst(rst), .st_we(st_we), .st_idx(st_idx), .st_val(st_val),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .upd_flags(upd_flags));
endmodule

// File: rtl/tpm_poller_chk.sv
module tpm_poller_chk #(
  parameter int NPTS = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            m_req,
  input logic            m_we,
  input logic [AW-1:0]   m_addr,
  input logic [DW-1:0]   m_wdata,
  input logic            m_ack,
  input logic            irq_timeout,
  input logic            rd_en,
  input logic [IW-1:0]   rd_idx,
  input logic [NPTS-1:0] upd_flags,
  input logic [AW-1:0]   cfg_mux_addr,
  input logic [AW-1:0]   cfg_sel_addr,
  input logic [AW-1:0]   cfg_en_addr,
  input logic [AW-1:0]   cfg_vld_addr,
  input logic [AW-1:0]   cfg_volt_addr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!m_req && !irq_timeout && upd_flags == '0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_timeout |=> !irq_timeout);

  // R3
  wr_target_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we) |-> (m_addr == cfg_mux_addr || m_addr == cfg_sel_addr || m_addr == cfg_en_addr));

  // R7
  rd_target_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we) |-> (m_addr == cfg_vld_addr || m_addr == cfg_volt_addr));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(m_ack)) |=> !upd_flags[$past(rd_idx)]);
endmodule

bind tpm_poller tpm_poller_chk #(.NPTS(NPTS), .AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_ack(m_ack), .irq_timeout(irq_timeout), .rd_en(rd_en),
  .rd_idx(rd_idx), .upd_flags(upd_flags), .cfg_mux_addr(cfg_mux_addr),
  .cfg_sel_addr(cfg_sel_addr), .cfg_en_addr(cfg_en_addr),
  .cfg_vld_addr(cfg_vld_addr), .cfg_volt_addr(cfg_volt_addr));

// File: tb/sim_tpm_poller.sv
module sim_tpm_poller;
  localparam int NPTS = 4;
  localparam int LAT  = 2;
  localparam logic [31:0] MUX_A = 32'h100, EN_A = 32'h104, SEL_A = 32'h200;
  localparam logic [31:0] VLD_A = 32'h300, VOLT_A = 32'h304;
  localparam logic [31:0] MUX_V = 32'h800, EN_V = 32'h800;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic [9:0] cfg_unit = 10'd1, cfg_round = 10'd1;
  logic [NPTS-1:0] cfg_en_mask = '0;
  logic [1:0] cfg_wr_ctl = 2'b11;
  logic [NPTS-1:0][31:0] cfg_sel_val;
  logic cfg_split = 1'b0, cfg_vld_high = 1'b1;
  logic [4:0] cfg_vld_pos = 5'd12, cfg_shift = 5'd0;
  logic [15:0] cfg_gap = 16'd3;
  logic [31:0] cfg_limit = 32'd8;
  logic m_req, m_we, m_ack = 1'b0, irq_timeout, rd_en = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic [1:0] rd_idx = '0;
  logic [11:0] rd_data;
  logic [NPTS-1:0] upd_flags;

  tpm_poller u0 (
    .clk(clk), .rst(rst), .cfg_unit(cfg_unit), .cfg_round(cfg_round),
    .cfg_en_mask(cfg_en_mask), .cfg_wr_ctl(cfg_wr_ctl),
    .cfg_mux_addr(MUX_A), .cfg_mux_val(MUX_V), .cfg_sel_addr(SEL_A),
    .cfg_sel_val(cfg_sel_val), .cfg_en_addr(EN_A), .cfg_en_val(EN_V),
    .cfg_vld_addr(VLD_A), .cfg_volt_addr(VOLT_A), .cfg_split(cfg_split),
    .cfg_vld_pos(cfg_vld_pos), .cfg_vld_high(cfg_vld_high), .cfg_shift(cfg_shift),
    .cfg_gap(cfg_gap), .cfg_limit(cfg_limit),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata), .irq_timeout(irq_timeout),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .upd_flags(upd_flags));

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } txn_t;
  txn_t        exp_q[$];
  logic [31:0] rsp_q[$];
  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0, req_cnt = 0;
  int last_poll = -1;
  bit gap_on = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back('{we: 1'b1, addr: a, data: d});
  endtask

  task automatic push_rd(input logic [31:0] a, input logic [31:0] rsp);
    exp_q.push_back('{we: 1'b0, addr: a, data: '0});
    rsp_q.push_back(rsp);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // slave + monitor: pops the scoreboard on every acknowledge
  initial begin
    int wcnt;
    logic [31:0] hold_a;
    txn_t e;
    wcnt = 0;
    hold_a = '0;
    forever begin
      @(negedge clk);
      if (irq_timeout) irq_cnt++;
      if (m_req) req_cnt++;
      if (m_ack) begin
        m_ack = 1'b0;
        wcnt = 0;
      end else if (m_req) begin
        if (wcnt == 0) hold_a = m_addr;
        else chk(m_addr == hold_a, "R10 addr held", m_addr, hold_a);
        if (wcnt == LAT) begin
          m_ack = 1'b1;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected bus access", m_addr, 0);
          end else begin
            e = exp_q.pop_front();
            chk(e.we == m_we && e.addr == m_addr && (!e.we || e.data == m_wdata),
                "R3 bus access", {m_we, m_addr, m_wdata}, {e.we, e.addr, e.data});
          end
          if (m_we && m_addr == EN_A) last_poll = -1;
          if (!m_we) begin
            m_rdata = (rsp_q.size() != 0) ? rsp_q.pop_front() : 32'h0;
            if (m_addr == VLD_A) begin
              if (gap_on && last_poll >= 0)
                chk(cyc - last_poll >= int'(cfg_gap) + 4, "R5 poll spacing",
                    cyc - last_poll, int'(cfg_gap) + 4);
              last_poll = cyc;
            end
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic read_pt(input int idx, input logic [11:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    rd_idx = 2'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic finish_round();
    wait (exp_q.size() == 0);
    repeat (8) @(negedge clk);
    cfg_en_mask = '0;
    chk(rsp_q.size() == 0, "R10 all responses used", rsp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t0;
    for (int i = 0; i < NPTS; i++) cfg_sel_val[i] = 32'h10 + 32'(i);
    // test A: points 0 and 2, both mux writes, same-word voltage
    cfg_en_mask = 4'b0101;
    push_wr(MUX_A, MUX_V); push_wr(SEL_A, 32'h10); push_wr(EN_A, EN_V); push_rd(VLD_A, 32'h1123);
    push_wr(MUX_A, MUX_V); push_wr(SEL_A, 32'h12); push_wr(EN_A, EN_V); push_rd(VLD_A, 32'h1ABC);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t0 = cyc;
    chk(!m_req && !irq_timeout, "R1 idle bus after reset", {m_req, irq_timeout}, 0);
    chk(upd_flags == 0, "R1 flags clear", upd_flags, 0);
    read_pt(0, 12'h000, "R1 result zero");
    wait (m_req);
    @(negedge clk);
    chk((cyc - t0) >= 250 && (cyc - t0) <= 270, "R2 first round start", cyc - t0, 258);
    finish_round();
    chk(upd_flags == 4'b0101, "R9 flags set", upd_flags, 4'b0101);
    read_pt(0, 12'h123, "R8 point0 result");
    read_pt(2, 12'hABC, "R8 point2 result");
    chk(upd_flags == 4'b0000, "R9 flags cleared by read", upd_flags, 0);

    // test B: selector only, active-low valid at bit 5, two retries, shift 4
    cfg_wr_ctl = 2'b01; cfg_vld_pos = 5'd5; cfg_vld_high = 1'b0; cfg_shift = 5'd4;
    gap_on = 1'b1;
    push_wr(SEL_A, 32'h11); push_wr(EN_A, EN_V);
    push_rd(VLD_A, 32'h20); push_rd(VLD_A, 32'h20); push_rd(VLD_A, 32'hABC0);
    cfg_en_mask = 4'b0010;
    finish_round();
    gap_on = 1'b0;
    chk(upd_flags == 4'b0010, "R4 active-low valid stored", upd_flags, 4'b0010);
    read_pt(1, 12'hABC, "R8 shifted result");

    // test C: mux only, split read of voltage
    cfg_wr_ctl = 2'b10; cfg_vld_pos = 5'd12; cfg_vld_high = 1'b1; cfg_shift = 5'd0;
    cfg_split = 1'b1;
    push_wr(MUX_A, MUX_V); push_wr(EN_A, EN_V);
    push_rd(VLD_A, 32'h1000); push_rd(VOLT_A, 32'h12345);
    cfg_en_mask = 4'b1000;
    finish_round();
    read_pt(3, 12'h345, "R7 split voltage");

    // test D: never valid, limit of two polls
    cfg_wr_ctl = 2'b00; cfg_split = 1'b0; cfg_limit = 32'd2;
    push_wr(EN_A, EN_V); push_rd(VLD_A, 32'h0); push_rd(VLD_A, 32'h0);
    cfg_en_mask = 4'b0001;
    finish_round();
    chk(irq_cnt == 1, "R6 one timeout pulse", irq_cnt, 1);
    chk(upd_flags[0] == 1'b0, "R6 flag untouched", upd_flags[0], 0);
    read_pt(0, 12'h123, "R6 result untouched");

    // test E: zero round count holds off all traffic
    cfg_round = 10'd0;
    repeat (2) @(negedge clk);
    req_cnt = 0;
    cfg_en_mask = 4'b0001;
    repeat (700) @(negedge clk);
    chk(req_cnt == 0, "R2 zero round count idle", req_cnt, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule